// File: doc/BRIEF.md
# Serial Receiver with Error Flags

This block turns an asynchronous serial line into characters. A 16x oversampling enable paces it. The line first passes through a synchroniser. The block then waits for a falling edge on the idle-high line. It confirms the start bit at the middle of that bit and samples every later bit at the centre of its bit period. Each finished character is checked for parity, stop bits and break. The character is then placed in a single holding register, together with a set of sticky flags that the host reads.

The host sets the word length, the receive parity mode, the stop-bit count and the receiver enable. It pulls characters with a data-read strobe and clears the error flags with a separate status-read strobe. Register decode and interrupt generation sit outside this block.

Top module: `serial_rx_flags`

## Requirements
- R1: A character starts on a high-to-low transition of the synchronised line while the receiver is idle. The start bit is sampled again at its midpoint (tick count 8). If the line is high there, the receiver returns to idle, and no flag or data changes.
- R2: Data bits arrive least significant bit first. `cfg_wlen` codes 00, 01, 10 and 11 select 5, 6, 7 and 8 data bits. The character is right-justified in `rx_byte`, and the unused upper bits read 0.
- R3: `cfg_par` codes 000 and 011 check even parity (data ones plus the parity bit give an even count). Codes 001 and 010 check odd parity. Codes 100, 101, 110 and 111 check nothing, and `flag_parity` stays 0.
- R4: With `cfg_par` codes 110 and 111 the frame has no parity bit, so the stop bit follows the last data bit directly.
- R5: `flag_frame` is set when any stop bit that is checked is sampled as 0.
- R6: With `cfg_stop2`=1 and 6 to 8 data bits, two stop bits are checked. With 5 data bits only one is checked, and a new start bit may follow it at once.
- R7: `flag_break` is set when the start bit, all data bits, the parity bit (if present) and all checked stop bits are 0.
- R8: If a character completes while `flag_ready` is 1 and no data read happens in that cycle, `flag_overrun` is set. The holding register keeps the older character and the new one is dropped.
- R9: While `cfg_rx_en` is 0 the receiver stays idle and ignores the line, so no character is produced.
- R10: `flag_ready` is set when a character is loaded into the holding register and cleared by `host_rd_data`. When a load and a data read fall in the same cycle, the load wins.
- R11: The parity, framing, overrun and break flags are sticky and are cleared only by `host_rd_stat`. When a new flag is set in the same cycle as a status read, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Enable pulse at 16 times the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| cfg_wlen | input | 2 | Word length code (5 + code bits) |
| cfg_par | input | 3 | Receive parity mode |
| cfg_stop2 | input | 1 | Two-stop-bit select |
| cfg_rx_en | input | 1 | Receiver enable |
| host_rd_data | input | 1 | Data read strobe, clears `flag_ready` |
| host_rd_stat | input | 1 | Status read strobe, clears the error flags |
| rx_byte | output | 8 | Holding register, right-justified |
| flag_ready | output | 1 | Unread character present |
| flag_parity | output | 1 | Sticky parity error |
| flag_frame | output | 1 | Sticky framing error |
| flag_overrun | output | 1 | Sticky overrun |
| flag_break | output | 1 | Sticky break received |

## Verification
Loading a finished character into the holding register can land in the same cycle as either host strobe. A data read in that cycle must not turn the load into an overrun or hide the new character. A status read in that cycle must not erase an error flag that the same character raises. The bench holds the oversampling enable high, so the load cycle is fixed: it comes 12 clocks after the last stop bit begins. The bench pulses both strobes in exactly that cycle while an unread character is still pending and the incoming stop bit is bad. It then expects the new byte to be shown with ready set, overrun clear and the framing flag set.

// File: rtl/srx_pkg.sv
package srx_pkg;

   localparam int SRX_BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP1,
      ST_STOP2
   } srx_state_e;

   typedef struct packed {
      logic [SRX_BYTE_W-1:0] data;
      logic                  pe;
      logic                  fe;
      logic                  brk;
   } srx_char_t;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic line_s,
   output logic fall
);
   logic [STAGES-1:0] q;
   logic              prev;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[i] <= 1'b1;
            else        q[i] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[i] <= 1'b1;
            else        q[i] <= q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= q[STAGES-1];
   end

   assign line_s = q[STAGES-1];
   assign fall   = prev & ~q[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
   import srx_pkg::*;
#(
   parameter int OVERSAMPLE = 16,
   parameter int WORD_MIN   = 5,
   parameter int WORD_MAX   = 8,
   parameter int WLEN_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line_s,
   input  logic              fall,
   input  logic              en,
   input  logic [WLEN_W-1:0] wlen,
   input  logic [2:0]        par_mode,
   input  logic              stop2,
   output logic              done,
   output srx_char_t         char_o
);
   localparam int CNT_W = $clog2(OVERSAMPLE);
   localparam int IDX_W = $clog2(WORD_MAX);
   localparam logic [CNT_W-1:0] MID  = CNT_W'(OVERSAMPLE / 2 - 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);
   localparam logic [IDX_W-1:0] IDX_BASE = IDX_W'(WORD_MIN - 1);

   srx_state_e            state;
   logic [CNT_W-1:0]      cnt;
   logic [IDX_W-1:0]      bit_idx;
   logic [SRX_BYTE_W-1:0] shreg;
   logic                  pbit;
   logic                  allz;
   logic                  fe_acc;

   logic [IDX_W-1:0] last_idx;
   logic             par_present;
   logic             par_check;
   logic             odd_exp;
   logic             two_stop;
   logic             centre;
   logic             par_bad;

   assign last_idx    = IDX_BASE + IDX_W'(wlen);
   assign par_present = (par_mode[2:1] != 2'b11);
   assign par_check   = ~par_mode[2];
   assign odd_exp     = par_mode[1] ^ par_mode[0];
   assign two_stop    = stop2 && (wlen != '0);
   assign centre      = tick && (cnt == LAST);
   assign par_bad     = par_check && ((^shreg ^ pbit) != odd_exp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         bit_idx <= '0;
         shreg   <= '0;
         pbit    <= 1'b0;
         allz    <= 1'b0;
         fe_acc  <= 1'b0;
         done    <= 1'b0;
         char_o  <= '0;
      end else begin
         done <= 1'b0;
         if (!en) begin
            state <= ST_IDLE;
         end else begin
            unique case (state)
               ST_IDLE: begin
                  if (fall) begin
                     state   <= ST_START;
                     cnt     <= '0;
                     bit_idx <= '0;
                     shreg   <= '0;
                     pbit    <= 1'b0;
                     allz    <= 1'b1;
                     fe_acc  <= 1'b0;
                  end
               end
               ST_START: begin
                  if (tick) begin
                     if (cnt == MID) begin
                        cnt <= '0;
                        if (line_s) state <= ST_IDLE;
                        else        state <= ST_DATA;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               ST_DATA: begin
                  if (tick) cnt <= cnt + 1'b1;
                  if (centre) begin
                     shreg[bit_idx] <= line_s;
                     if (line_s) allz <= 1'b0;
                     if (bit_idx == last_idx) state <= par_present ? ST_PAR : ST_STOP1;
                     else                     bit_idx <= bit_idx + 1'b1;
                  end
               end
               ST_PAR: begin
                  if (tick) cnt <= cnt + 1'b1;
                  if (centre) begin
                     pbit <= line_s;
                     if (line_s) allz <= 1'b0;
                     state <= ST_STOP1;
                  end
               end
               ST_STOP1: begin
                  if (tick) cnt <= cnt + 1'b1;
                  if (centre) begin
                     if (two_stop) begin
                        fe_acc <= ~line_s;
                        if (line_s) allz <= 1'b0;
                        state <= ST_STOP2;
                     end else begin
                        done        <= 1'b1;
                        char_o.data <= shreg;
                        char_o.pe   <= par_bad;
                        char_o.fe   <= ~line_s;
                        char_o.brk  <= allz & ~line_s;
                        state       <= ST_IDLE;
                     end
                  end
               end
               ST_STOP2: begin
                  if (tick) cnt <= cnt + 1'b1;
                  if (centre) begin
                     done        <= 1'b1;
                     char_o.data <= shreg;
                     char_o.pe   <= par_bad;
                     char_o.fe   <= fe_acc | ~line_s;
                     char_o.brk  <= allz & ~line_s;
                     state       <= ST_IDLE;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/srx_hold.sv
module srx_hold
   import srx_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  done,
   input  srx_char_t             char_i,
   input  logic                  rd_data,
   input  logic                  rd_stat,
   output logic [SRX_BYTE_W-1:0] rx_byte,
   output logic                  ready,
   output logic                  pe,
   output logic                  fe,
   output logic                  ov,
   output logic                  brk
);
   logic ready_eff;
   logic load;

   assign ready_eff = ready & ~rd_data;
   assign load      = done & ~ready_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_byte <= '0;
         ready   <= 1'b0;
         pe      <= 1'b0;
         fe      <= 1'b0;
         ov      <= 1'b0;
         brk     <= 1'b0;
      end else begin
         if (load) rx_byte <= char_i.data;
         ready <= ready_eff | done;
         ov    <= (ov  & ~rd_stat) | (done & ready_eff);
         pe    <= (pe  & ~rd_stat) | (load & char_i.pe);
         fe    <= (fe  & ~rd_stat) | (load & char_i.fe);
         brk   <= (brk & ~rd_stat) | (load & char_i.brk);
      end
   end
endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags
   import srx_pkg::*;
#(
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2,
   parameter int WORD_MIN    = 5,
   parameter int WORD_MAX    = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       os_tick,
   input  logic       rx_in,
   input  logic [1:0] cfg_wlen,
   input  logic [2:0] cfg_par,
   input  logic       cfg_stop2,
   input  logic       cfg_rx_en,
   input  logic       host_rd_data,
   input  logic       host_rd_stat,
   output logic [7:0] rx_byte,
   output logic       flag_ready,
   output logic       flag_parity,
   output logic       flag_frame,
   output logic       flag_overrun,
   output logic       flag_break
);
   localparam int WLEN_W = 2;

   if (OVERSAMPLE < 4 || (OVERSAMPLE & (OVERSAMPLE - 1)) != 0) begin : g_bad_os
      $error("OVERSAMPLE must be a power of two of at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (WORD_MAX != SRX_BYTE_W) begin : g_bad_max
      $error("WORD_MAX must equal the holding register width");
   end
   if (WORD_MAX - WORD_MIN != (1 << WLEN_W) - 1) begin : g_bad_span
      $error("word length span must match the width of the length code");
   end

   logic      line_s;
   logic      fall;
   logic      fr_done;
   srx_char_t fr_char;

   srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (rx_in),
      .line_s (line_s),
      .fall   (fall)
   );

   srx_framer #(
      .OVERSAMPLE (OVERSAMPLE),
      .WORD_MIN   (WORD_MIN),
      .WORD_MAX   (WORD_MAX),
      .WLEN_W     (WLEN_W)
   ) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (os_tick),
      .line_s   (line_s),
      .fall     (fall),
      .en       (cfg_rx_en),
      .wlen     (cfg_wlen),
      .par_mode (cfg_par),
      .stop2    (cfg_stop2),
      .done     (fr_done),
      .char_o   (fr_char)
   );

   srx_hold u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .done    (fr_done),
      .char_i  (fr_char),
      .rd_data (host_rd_data),
      .rd_stat (host_rd_stat),
      .rx_byte (rx_byte),
      .ready   (flag_ready),
      .pe      (flag_parity),
      .fe      (flag_frame),
      .ov      (flag_overrun),
      .brk     (flag_break)
   );
endmodule

// File: rtl/srx_chk.sv
module srx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_rx_en,
   input logic       par_nochk,
   input logic       host_rd_data,
   input logic       host_rd_stat,
   input logic       fr_done,
   input logic [7:0] rx_byte,
   input logic       flag_ready,
   input logic       flag_parity,
   input logic       flag_frame,
   input logic       flag_overrun,
   input logic       flag_break
);
   // R9: with the receiver disabled two cycles back, no character can arrive
   a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_rx_en, 2) |-> !$rose(flag_ready));

   // R10: a data read with no load in the same cycle empties the holding register
   a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd_data && !fr_done |=> !flag_ready);

   // R8: completion onto an unread character flags overrun and keeps the old byte
   a_r8_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      fr_done && flag_ready && !host_rd_data |=> flag_overrun && $stable(rx_byte));

   // R11: status read without a load clears every error flag
   a_r11_stat_clears: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd_stat && !fr_done |=> !flag_parity && !flag_frame && !flag_overrun && !flag_break);

   // R11: the framing flag only falls after a status read
   a_r11_frame_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_frame) |-> $past(host_rd_stat));

   // R3: with checking off the parity flag cannot rise
   a_r3_nochk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $past(par_nochk, 2) && !$past(flag_parity) |-> !flag_parity);

   // R7: a newly flagged break comes with an all-zero character on show
   a_r7_break_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_break) |-> flag_ready && (rx_byte == 8'h00));
endmodule

bind serial_rx_flags srx_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_rx_en    (cfg_rx_en),
   .par_nochk    (cfg_par[2]),
   .host_rd_data (host_rd_data),
   .host_rd_stat (host_rd_stat),
   .fr_done      (fr_done),
   .rx_byte      (rx_byte),
   .flag_ready   (flag_ready),
   .flag_parity  (flag_parity),
   .flag_frame   (flag_frame),
   .flag_overrun (flag_overrun),
   .flag_break   (flag_break)
);

// File: tb/tb_serial_rx_flags.sv
module tb_serial_rx_flags;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b1;
   logic       rx_in = 1'b1;
   logic [1:0] cfg_wlen = 2'd3;
   logic [2:0] cfg_par = 3'd6;
   logic       cfg_stop2 = 1'b0;
   logic       cfg_rx_en = 1'b1;
   logic       host_rd_data = 1'b0;
   logic       host_rd_stat = 1'b0;
   logic [7:0] rx_byte;
   logic       flag_ready, flag_parity, flag_frame, flag_overrun, flag_break;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   serial_rx_flags dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .os_tick      (os_tick),
      .rx_in        (rx_in),
      .cfg_wlen     (cfg_wlen),
      .cfg_par      (cfg_par),
      .cfg_stop2    (cfg_stop2),
      .cfg_rx_en    (cfg_rx_en),
      .host_rd_data (host_rd_data),
      .host_rd_stat (host_rd_stat),
      .rx_byte      (rx_byte),
      .flag_ready   (flag_ready),
      .flag_parity  (flag_parity),
      .flag_frame   (flag_frame),
      .flag_overrun (flag_overrun),
      .flag_break   (flag_break)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one bit time is 16 clocks because the oversampling enable stays high
   task automatic send_bit(input logic b);
      rx_in = b;
      repeat (16) @(negedge clk);
   endtask

   // last stop bit: optional strobes in the cycle the character is loaded
   task automatic send_last_stop(input logic b, input bit strobe);
      rx_in = b;
      repeat (11) @(negedge clk);
      if (strobe) begin
         host_rd_data = 1'b1;
         host_rd_stat = 1'b1;
      end
      @(negedge clk);
      host_rd_data = 1'b0;
      host_rd_stat = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] d, input int nbits, input bit haspar,
                             input logic p, input int nstop, input logic s1,
                             input logic s2, input bit strobe);
      send_bit(1'b0);
      for (int i = 0; i < nbits; i++) send_bit(d[i]);
      if (haspar) send_bit(p);
      if (nstop == 2) begin
         send_bit(s1);
         send_last_stop(s2, strobe);
      end else begin
         send_last_stop(s1, strobe);
      end
      rx_in = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic host_read();
      host_rd_data = 1'b1;
      host_rd_stat = 1'b1;
      @(negedge clk);
      host_rd_data = 1'b0;
      host_rd_stat = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R10 reset ready", flag_ready, 0);
      check("R11 reset flags", {flag_parity, flag_frame, flag_overrun, flag_break}, 0);
      check("R2 reset byte", rx_byte, 0);

      // sweep: every length, parity mode and stop select; good and bad parity
      for (int wl = 0; wl < 4; wl++) begin
         for (int pc = 0; pc < 8; pc++) begin
            for (int st = 0; st < 2; st++) begin
               for (int v = 0; v < 2; v++) begin
                  logic [7:0] d, dm;
                  logic       haspar, chk, odd, p, exp_pe;
                  int         nb, ns;
                  nb     = 5 + wl;
                  d      = 8'((wl * 37 + pc * 11 + st * 5 + v * 90 + 7) & 255);
                  dm     = d & 8'((1 << nb) - 1);
                  haspar = (pc < 6);
                  chk    = (pc < 4);
                  odd    = 1'(pc & 1) ^ 1'((pc >> 1) & 1);
                  if (chk) p = (^dm) ^ odd ^ 1'(v);
                  else     p = 1'(v);
                  exp_pe = chk && (v == 1);
                  ns     = (st == 1 && wl != 0) ? 2 : 1;
                  @(negedge clk);
                  cfg_wlen  = 2'(wl);
                  cfg_par   = 3'(pc);
                  cfg_stop2 = 1'(st);
                  send_frame(d, nb, haspar, p, ns, 1'b1, 1'b1, 1'b0);
                  check(haspar ? "R2 data" : "R4 data no parity bit", rx_byte, dm);
                  check("R10 ready set", flag_ready, 1);
                  check("R3 parity flag", flag_parity, exp_pe);
                  check(ns == 2 ? "R6 two good stops" : "R5 good stop", flag_frame, 0);
                  check("R7 no break", flag_break, 0);
                  check("R8 no overrun", flag_overrun, 0);
                  host_read();
                  check("R10 ready cleared", flag_ready, 0);
                  check("R11 parity cleared", flag_parity, 0);
               end
            end
         end
      end

      // framing error: 8 bits, no parity, stop sampled low
      cfg_wlen = 2'd3; cfg_par = 3'd6; cfg_stop2 = 1'b0;
      send_frame(8'hA5, 8, 1'b0, 1'b0, 1, 1'b0, 1'b1, 1'b0);
      check("R5 frame data", rx_byte, 8'hA5);
      check("R5 frame flag", flag_frame, 1);
      check("R7 not break", flag_break, 0);
      host_read();
      check("R11 frame cleared", flag_frame, 0);

      // break: all zero with even parity bit 0 and low stop
      cfg_par = 3'd0;
      send_frame(8'h00, 8, 1'b1, 1'b0, 1, 1'b0, 1'b0, 1'b0);
      check("R7 break flag", flag_break, 1);
      check("R7 break byte", rx_byte, 0);
      check("R7 break frame", flag_frame, 1);
      check("R7 break parity ok", flag_parity, 0);
      host_read();
      check("R11 break cleared", flag_break, 0);

      // second stop low with 7 bits
      cfg_wlen = 2'd2; cfg_par = 3'd6; cfg_stop2 = 1'b1;
      send_frame(8'h5A, 7, 1'b0, 1'b0, 2, 1'b1, 1'b0, 1'b0);
      check("R6 second stop low", flag_frame, 1);
      check("R6 data", rx_byte, 8'h5A);
      host_read();

      // 5 bits with stop select: one stop then an immediate new start bit
      cfg_wlen = 2'd0;
      send_bit(1'b0);
      for (int i = 0; i < 5; i++) send_bit(1'((5'h15 >> i) & 1));
      send_bit(1'b1);
      rx_in = 1'b0;
      repeat (8) @(negedge clk);
      check("R6 five-bit first char", rx_byte, 8'h15);
      check("R6 five-bit single stop", flag_frame, 0);
      host_read();
      repeat (6) @(negedge clk);
      for (int i = 0; i < 5; i++) send_bit(1'((5'h0A >> i) & 1));
      send_last_stop(1'b1, 1'b0);
      rx_in = 1'b1;
      repeat (6) @(negedge clk);
      check("R6 five-bit back to back", rx_byte, 8'h0A);
      check("R6 back to back ready", flag_ready, 1);
      check("R6 back to back frame", flag_frame, 0);
      host_read();

      // overrun: two characters without a read
      cfg_wlen = 2'd3; cfg_stop2 = 1'b0;
      send_frame(8'h3C, 8, 1'b0, 1'b0, 1, 1'b1, 1'b1, 1'b0);
      send_frame(8'hC3, 8, 1'b0, 1'b0, 1, 1'b1, 1'b1, 1'b0);
      check("R8 overrun flag", flag_overrun, 1);
      check("R8 older byte kept", rx_byte, 8'h3C);
      check("R8 ready held", flag_ready, 1);
      host_read();
      check("R11 overrun cleared", flag_overrun, 0);

      // short low glitch: start rejected at its midpoint
      rx_in = 1'b0;
      repeat (4) @(negedge clk);
      rx_in = 1'b1;
      repeat (200) @(negedge clk);
      check("R1 glitch no char", flag_ready, 0);
      check("R1 glitch no flags", {flag_parity, flag_frame, flag_overrun, flag_break}, 0);

      // disabled receiver ignores a whole frame
      cfg_rx_en = 1'b0;
      send_frame(8'h81, 8, 1'b0, 1'b0, 1, 1'b0, 1'b0, 1'b0);
      check("R9 disabled no char", flag_ready, 0);
      check("R9 disabled no flags", {flag_frame, flag_break}, 0);
      cfg_rx_en = 1'b1;
      repeat (4) @(negedge clk);
      send_frame(8'h42, 8, 1'b0, 1'b0, 1, 1'b1, 1'b1, 1'b0);
      check("R9 re-enabled char", rx_byte, 8'h42);
      host_read();

      // both strobes in the load cycle, an unread character pending, bad stop
      send_frame(8'h11, 8, 1'b0, 1'b0, 1, 1'b1, 1'b1, 1'b0);
      send_frame(8'hE7, 8, 1'b0, 1'b0, 1, 1'b0, 1'b0, 1'b1);
      check("R10 load beats read byte", rx_byte, 8'hE7);
      check("R10 load beats read ready", flag_ready, 1);
      check("R8 read in load cycle no overrun", flag_overrun, 0);
      check("R11 set beats clear", flag_frame, 1);
      host_read();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule